// File: doc/BRIEF.md
# Address Range Access Protection Checker

This block screens every processor transaction against a small set of programmable protection windows. A window is a power-of-two address range with an enable flag and three permission flags: no access at all, no writes, and no caching. If a transaction address falls in an enabled window, the window's flags decide the outcome. The block reports allow or deny one cycle after the transaction is presented. It also reports when a cacheable access is allowed into a region that must not be cached. An address that lies in no window is allowed.

A single configuration port writes and reads the window words with byte strobes. The same port moves the internal register space, which can never be blocked. It also clears the violation record. The violation record keeps the first denied address and its transaction type until software clears it. The block does no address decoding, no remapping and no bus error signalling.

Top module: `apg_guard`

## Requirements
- R1: After reset, no result is valid, allow, deny and cache-block are low, no violation is recorded, every window word and size word reads zero, and the internal space register (offset 0x84) reads 0x0000_1400.
- R2: Window i has its attribute word at offset 0x10*i and its size word at offset 0x10*i+8. Attribute word bits [15:0] hold address bits [31:16] of the base, bit 20 is no-access, bit 21 is no-write, bit 22 is no-cache and bit 31 is enable. The size word holds in bits [15:0] the window size in 64 KB units minus one. All other bits read as zero.
- R3: A write changes only the byte lanes whose strobe is high. A write of strobe 4'b1000 with data zero disables a window and leaves its base and permission fields unchanged.
- R4: An enabled window with a nonzero size word matches an address when address bits [31:16] and the base field differ only in bit positions set in the size word. A size word of zero closes the window.
- R5: A transaction presented with txn_valid produces, one clock later, a one-cycle res_valid with exactly one of res_allow and res_deny high. Without res_valid all three result outputs are low.
- R6: A matched window denies every access when its no-access flag is set, and denies writes when its no-write flag is set. Otherwise the access is allowed. An address that matches no window is allowed.
- R7: res_cache_block rises together with res_allow when a cacheable transaction is allowed by a matched window whose no-cache flag is set. It stays low on a denied access.
- R8: When several enabled windows match, the window with the lowest index alone supplies the permission flags.
- R9: An address whose bits [31:16] equal bits [15:0] of the internal space register is always allowed with cache-block low, whatever windows cover it.
- R10: A denial loads viol_addr, viol_write and viol_cache and sets viol_valid if no violation is held. A held record is not overwritten by later denials. A write to offset 0x80 with strobe bit 0 and data bit 0 high clears viol_valid.
- R11: When a clear and a new denial fall on the same edge, the new denial is recorded. A configuration write on the same edge as a transaction does not affect that transaction, which is judged with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_be | input | 4 | Byte strobes for the write |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | 32 | Transaction address |
| txn_write | input | 1 | Transaction is a write |
| txn_cache | input | 1 | Transaction is cacheable |
| res_valid | output | 1 | Result valid, one cycle after txn_valid |
| res_allow | output | 1 | Access allowed |
| res_deny | output | 1 | Access denied |
| res_cache_block | output | 1 | Allowed, but the region must not be cached |
| viol_valid | output | 1 | A violation is recorded |
| viol_addr | output | 32 | Address of the recorded violation |
| viol_write | output | 1 | Recorded violation was a write |
| viol_cache | output | 1 | Recorded violation was cacheable |

## Verification
Two pairs of events can land on the same clock edge. The first is a status clear together with a new denial. The second is a window reprogram together with a transaction that the reprogram would change. The bench drives both pairs on the same edge. It checks that the clear does not swallow the new denial, which must be recorded. It also checks that the transaction is judged with the window as it stood before the write, and that the next transaction sees the new contents. Random traffic aimed at and just beyond the programmed windows, with occasional clears, covers the same meeting points again.

// File: rtl/apg_pkg.sv
package apg_pkg;

   // attribute word flag positions (software-visible layout)
   localparam int F_NOACC   = 20;
   localparam int F_NOWR    = 21;
   localparam int F_NOCACHE = 22;
   localparam int F_EN      = 31;

   // register stride and in-window offsets
   localparam int WIN_STRIDE_LOG2 = 4;
   localparam logic [3:0] OFS_ATTR = 4'h0;
   localparam logic [3:0] OFS_SIZE = 4'h8;

   typedef struct packed {
      logic no_acc;
      logic no_wr;
      logic no_cache;
   } perm_t;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
      return m;
   endfunction

   function automatic logic [31:0] merge_word(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input logic [3:0]  be);
      logic [31:0] m;
      m = lane_mask(be);
      return (cur & ~m) | (wd & m);
   endfunction

endpackage

// File: rtl/apg_window.sv
module apg_window
   import apg_pkg::*;
#(
   parameter int PAGE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_attr,
   input  logic              wr_size,
   input  logic [3:0]        be,
   input  logic [31:0]       wdata,
   input  logic [PAGE_W-1:0] page,
   output logic              hit,
   output perm_t             perm,
   output logic [31:0]       attr_word,
   output logic [31:0]       size_word
);

   logic [PAGE_W-1:0] base_q;
   logic [PAGE_W-1:0] mask_q;
   logic              en_q;
   perm_t             perm_q;
   logic [31:0]       nxt_attr;
   logic [31:0]       nxt_size;

   always_comb begin
      attr_word                = '0;
      attr_word[PAGE_W-1:0]    = base_q;
      attr_word[F_NOACC]       = perm_q.no_acc;
      attr_word[F_NOWR]        = perm_q.no_wr;
      attr_word[F_NOCACHE]     = perm_q.no_cache;
      attr_word[F_EN]          = en_q;
      size_word                = '0;
      size_word[PAGE_W-1:0]    = mask_q;
   end

   assign nxt_attr = merge_word(attr_word, wdata, be);
   assign nxt_size = merge_word(size_word, wdata, be);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         en_q   <= 1'b0;
         perm_q <= '0;
      end else begin
         if (wr_attr) begin
            base_q          <= nxt_attr[PAGE_W-1:0];
            en_q            <= nxt_attr[F_EN];
            perm_q.no_acc   <= nxt_attr[F_NOACC];
            perm_q.no_wr    <= nxt_attr[F_NOWR];
            perm_q.no_cache <= nxt_attr[F_NOCACHE];
         end
         if (wr_size) mask_q <= nxt_size[PAGE_W-1:0];
      end
   end

   // size field is a mask of don't-care page bits; zero mask means closed
   assign hit  = en_q && (|mask_q) && (((page ^ base_q) & ~mask_q) == '0);
   assign perm = perm_q;

   // R3
   top_lane_keeps_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_attr && be == 4'b1000) |=> ($stable(base_q) && $stable(perm_q)));

   // R3
   no_top_lane_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_attr && !be[3]) |=> $stable(en_q));

endmodule

// File: rtl/apg_select.sv
module apg_select
   import apg_pkg::*;
#(
   parameter int NUM_WIN = 8
) (
   input  logic [NUM_WIN-1:0] hit,
   input  perm_t              perm [NUM_WIN],
   output logic               any_hit,
   output perm_t              sel
);

   localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

   logic [IDX_W-1:0] sel_idx;

   // walk from the top so the lowest index is the last to win
   always_comb begin
      any_hit = 1'b0;
      sel     = '0;
      sel_idx = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit[i]) begin
            any_hit = 1'b1;
            sel     = perm[i];
            sel_idx = IDX_W'(i);
         end
      end
   end

   // R8
   always_comb begin
      if (any_hit) begin
         lowest_win_chk: assert (hit[sel_idx] &&
            ((hit & ((NUM_WIN'(1) << sel_idx) - NUM_WIN'(1))) == '0));
      end
   end

endmodule

// File: rtl/apg_status.sv
module apg_status #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              clear,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_write,
   input  logic              is_cache,
   output logic              valid,
   output logic [ADDR_W-1:0] addr_q,
   output logic              write_q,
   output logic              cache_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         addr_q  <= '0;
         write_q <= 1'b0;
         cache_q <= 1'b0;
      end else if (capture && (!valid || clear)) begin
         valid   <= 1'b1;
         addr_q  <= addr;
         write_q <= is_write;
         cache_q <= is_cache;
      end else if (clear) begin
         valid   <= 1'b0;
      end
   end

   // R10
   record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clear) |=> (valid && $stable(addr_q) && $stable(write_q)));

   // R10
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !capture) |=> !valid);

   // R11
   clear_and_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && capture) |=> (valid && addr_q == $past(addr)));

endmodule

// File: rtl/apg_guard.sv
module apg_guard
   import apg_pkg::*;
#(
   parameter int          NUM_WIN      = 8,
   parameter int          ADDR_W       = 32,
   parameter int          GRAN_LOG2    = 16,
   parameter int          INT_LOG2     = 16,
   parameter int          REG_AW       = 8,
   parameter logic [31:0] INT_BASE_RST = 32'h0000_1400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_be,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              txn_valid,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic              txn_write,
   input  logic              txn_cache,
   output logic              res_valid,
   output logic              res_allow,
   output logic              res_deny,
   output logic              res_cache_block,
   output logic              viol_valid,
   output logic [ADDR_W-1:0] viol_addr,
   output logic              viol_write,
   output logic              viol_cache
);

   localparam int PAGE_W   = ADDR_W - GRAN_LOG2;
   localparam int INT_SKIP = INT_LOG2 - GRAN_LOG2;
   localparam int WIDX_W   = REG_AW - WIN_STRIDE_LOG2;
   localparam int CLR_OFS  = NUM_WIN << WIN_STRIDE_LOG2;
   localparam int INT_OFS  = CLR_OFS + 4;

   // elaboration-time parameter checks
   if (NUM_WIN < 1 || NUM_WIN > 16) begin : g_bad_nwin
      $error("apg_guard: NUM_WIN out of range");
   end
   if (PAGE_W < 1 || PAGE_W > 20) begin : g_bad_page
      $error("apg_guard: page field must fit bits [19:0]");
   end
   if (INT_LOG2 < GRAN_LOG2 || INT_LOG2 >= ADDR_W) begin : g_bad_int
      $error("apg_guard: INT_LOG2 out of range");
   end
   if (INT_OFS + 4 > (1 << REG_AW)) begin : g_bad_aw
      $error("apg_guard: REG_AW too small for register map");
   end

   // configuration decode
   logic [WIDX_W-1:0] win_idx;
   logic              in_win;
   logic              clr_req;
   logic              wr_int;

   assign win_idx = cfg_addr[REG_AW-1:WIN_STRIDE_LOG2];
   assign in_win  = int'(cfg_addr) < CLR_OFS;
   assign clr_req = cfg_we && (int'(cfg_addr) == CLR_OFS) && cfg_be[0] && cfg_wdata[0];
   assign wr_int  = cfg_we && (int'(cfg_addr) == INT_OFS);

   // windows
   logic [NUM_WIN-1:0] hit_vec;
   logic [NUM_WIN-1:0] wr_attr;
   logic [NUM_WIN-1:0] wr_size;
   perm_t              perm_arr   [NUM_WIN];
   logic [31:0]        attr_words [NUM_WIN];
   logic [31:0]        size_words [NUM_WIN];
   logic [PAGE_W-1:0]  txn_page;

   assign txn_page = txn_addr[ADDR_W-1:GRAN_LOG2];

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      assign wr_attr[i] = cfg_we && in_win && (win_idx == WIDX_W'(i))
                          && (cfg_addr[WIN_STRIDE_LOG2-1:0] == OFS_ATTR);
      assign wr_size[i] = cfg_we && in_win && (win_idx == WIDX_W'(i))
                          && (cfg_addr[WIN_STRIDE_LOG2-1:0] == OFS_SIZE);
      apg_window #(.PAGE_W(PAGE_W)) u_win (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_attr   (wr_attr[i]),
         .wr_size   (wr_size[i]),
         .be        (cfg_be),
         .wdata     (cfg_wdata),
         .page      (txn_page),
         .hit       (hit_vec[i]),
         .perm      (perm_arr[i]),
         .attr_word (attr_words[i]),
         .size_word (size_words[i])
      );
   end

   // internal register space base (always exempt)
   logic [PAGE_W-1:0] int_base_q;
   logic [31:0]       int_word;
   logic [31:0]       int_nxt;

   always_comb begin
      int_word             = '0;
      int_word[PAGE_W-1:0] = int_base_q;
   end
   assign int_nxt = merge_word(int_word, cfg_wdata, cfg_be);

   always_ff @(posedge clk) begin
      if (!rst_n)      int_base_q <= INT_BASE_RST[PAGE_W-1:0];
      else if (wr_int) int_base_q <= int_nxt[PAGE_W-1:0];
   end

   // readback
   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (in_win && win_idx == WIDX_W'(i)) begin
            if (cfg_addr[WIN_STRIDE_LOG2-1:0] == OFS_ATTR) cfg_rdata = attr_words[i];
            if (cfg_addr[WIN_STRIDE_LOG2-1:0] == OFS_SIZE) cfg_rdata = size_words[i];
         end
      end
      if (int'(cfg_addr) == INT_OFS) cfg_rdata = int_word;
   end

   // priority pick and decision
   logic  any_hit;
   perm_t sel;
   logic  exempt;
   logic  deny_c;
   logic  cblk_c;

   apg_select #(.NUM_WIN(NUM_WIN)) u_sel (
      .hit     (hit_vec),
      .perm    (perm_arr),
      .any_hit (any_hit),
      .sel     (sel)
   );

   always_comb begin
      exempt = txn_addr[ADDR_W-1:INT_LOG2] == int_base_q[PAGE_W-1:INT_SKIP];
      deny_c = !exempt && any_hit && (sel.no_acc || (txn_write && sel.no_wr));
      cblk_c = !exempt && any_hit && !deny_c && txn_cache && sel.no_cache;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid       <= 1'b0;
         res_allow       <= 1'b0;
         res_deny        <= 1'b0;
         res_cache_block <= 1'b0;
      end else begin
         res_valid       <= txn_valid;
         res_allow       <= txn_valid && !deny_c;
         res_deny        <= txn_valid && deny_c;
         res_cache_block <= txn_valid && cblk_c;
      end
   end

   apg_status #(.ADDR_W(ADDR_W)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (txn_valid && deny_c),
      .clear    (clr_req),
      .addr     (txn_addr),
      .is_write (txn_write),
      .is_cache (txn_cache),
      .valid    (viol_valid),
      .addr_q   (viol_addr),
      .write_q  (viol_write),
      .cache_q  (viol_cache)
   );

   // R5
   result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> res_valid);

   // R5
   result_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> !res_valid);

   // R5
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_allow != res_deny));

   // R5
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !(res_allow || res_deny || res_cache_block));

   // R7
   cblk_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_cache_block |-> res_allow);

   // R9
   exempt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && exempt) |=> (res_allow && !res_cache_block));

   // R10
   deny_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_deny |-> viol_valid);

endmodule

// File: tb/apg_guard_tb.sv
module apg_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [3:0]  cfg_be;
   logic [7:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        txn_valid;
   logic [31:0] txn_addr;
   logic        txn_write;
   logic        txn_cache;
   logic        res_valid, res_allow, res_deny, res_cache_block;
   logic        viol_valid;
   logic [31:0] viol_addr;
   logic        viol_write, viol_cache;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // reference model state
   logic [31:0] mb [8];
   logic [31:0] ms [8];
   logic [31:0] mint;
   logic        sv;
   logic [31:0] sa;
   logic        sw, sc;

   always #5 clk = ~clk;

   apg_guard u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .txn_valid(txn_valid), .txn_addr(txn_addr),
      .txn_write(txn_write), .txn_cache(txn_cache),
      .res_valid(res_valid), .res_allow(res_allow), .res_deny(res_deny),
      .res_cache_block(res_cache_block),
      .viol_valid(viol_valid), .viol_addr(viol_addr),
      .viol_write(viol_write), .viol_cache(viol_cache)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mrg(input logic [31:0] c, input logic [31:0] d,
                                       input logic [3:0] be);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
      return (c & ~m) | (d & m);
   endfunction

   // expected {allow, deny, cache_block} from R4, R6, R7, R8, R9
   function automatic logic [2:0] decide(input logic [31:0] a, input logic w, input logic c);
      logic d;
      if (a[31:16] == mint[15:0]) return 3'b100;
      for (int i = 0; i < 8; i++) begin
         if (mb[i][31] && ms[i][15:0] != 16'h0 &&
             ((a[31:16] ^ mb[i][15:0]) & ~ms[i][15:0]) == 16'h0) begin
            d = mb[i][20] | (w & mb[i][21]);
            return {!d, d, !d & c & mb[i][22]};
         end
      end
      return 3'b100;
   endfunction

   function automatic logic [31:0] mrd(input logic [7:0] a);
      if (a < 8'h80 && a[3:0] == 4'h0) return mb[a[6:4]];
      if (a < 8'h80 && a[3:0] == 4'h8) return ms[a[6:4]];
      if (a == 8'h84) return mint;
      return 32'h0;
   endfunction

   task automatic model_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      if (a < 8'h80 && a[3:0] == 4'h0) mb[a[6:4]] = mrg(mb[a[6:4]], d, be) & 32'h8070_FFFF;
      else if (a < 8'h80 && a[3:0] == 4'h8) ms[a[6:4]] = mrg(ms[a[6:4]], d, be) & 32'h0000_FFFF;
      else if (a == 8'h80 && be[0] && d[0]) sv = 1'b0;
      else if (a == 8'h84) mint = mrg(mint, d, be) & 32'h0000_FFFF;
   endtask

   task automatic cfg_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_wr(a, be, d);
   endtask

   task automatic chk_rd(input string req, input logic [7:0] a);
      @(negedge clk);
      cfg_addr = a;
      #1;
      chk(req, {32'h0, cfg_rdata}, {32'h0, mrd(a)});
   endtask

   task automatic chk_stat(input string req);
      chk(req, {viol_valid, viol_valid ? viol_addr : 32'h0,
                viol_valid ? {viol_write, viol_cache} : 2'b00, 29'h0},
               {sv, sv ? sa : 32'h0, sv ? {sw, sc} : 2'b00, 29'h0});
   endtask

   // one transaction; optional same-edge config write (R11)
   task automatic txn_cfg(input string req, input logic [31:0] a, input logic w, input logic c,
                          input logic do_cfg, input logic [7:0] ca, input logic [3:0] cbe,
                          input logic [31:0] cd);
      logic [2:0] e;
      logic       svb, clr;
      @(negedge clk);
      txn_valid = 1'b1; txn_addr = a; txn_write = w; txn_cache = c;
      if (do_cfg) begin
         cfg_we = 1'b1; cfg_addr = ca; cfg_be = cbe; cfg_wdata = cd;
      end
      e = decide(a, w, c);
      @(negedge clk);
      txn_valid = 1'b0; cfg_we = 1'b0;
      chk(req, {60'h0, res_valid, res_allow, res_deny, res_cache_block},
               {60'h0, 1'b1, e});
      svb = sv;
      clr = do_cfg && ca == 8'h80 && cbe[0] && cd[0];
      if (do_cfg) model_wr(ca, cbe, cd);
      if (e[1] && (!svb || clr)) begin
         sv = 1'b1; sa = a; sw = w; sc = c;
      end
      chk_stat("R10");
   endtask

   task automatic txn(input string req, input logic [31:0] a, input logic w, input logic c);
      txn_cfg(req, a, w, c, 1'b0, 8'h0, 4'h0, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] pg, m;
      int k, j;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_be = 4'h0; cfg_addr = 8'h0; cfg_wdata = 32'h0;
      txn_valid = 1'b0; txn_addr = 32'h0; txn_write = 1'b0; txn_cache = 1'b0;
      for (int i = 0; i < 8; i++) begin mb[i] = 32'h0; ms[i] = 32'h0; end
      mint = 32'h0000_1400; sv = 1'b0; sa = 32'h0; sw = 1'b0; sc = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1", {60'h0, res_valid, res_allow, res_deny, res_cache_block}, 64'h0);
      chk("R1", {63'h0, viol_valid}, 64'h0);
      chk_rd("R1", 8'h00);
      chk_rd("R1", 8'h78);
      chk_rd("R1", 8'h84);
      chk("R1", {32'h0, cfg_rdata}, 64'h0000_1400);

      // R2 field layout and readback
      cfg_wr(8'h00, 4'hF, 32'hFFFF_FFFF);
      chk_rd("R2", 8'h00);
      chk("R2", {32'h0, cfg_rdata}, 64'h8070_FFFF);
      cfg_wr(8'h08, 4'hF, 32'hFFFF_FFFF);
      chk_rd("R2", 8'h08);
      cfg_wr(8'h00, 4'hF, 32'h8010_2000);
      cfg_wr(8'h08, 4'hF, 32'h0000_000F);
      chk_rd("R2", 8'h00);

      // R4 / R6 window edges, no-access
      txn("R4", 32'h200F_FFFC, 1'b0, 1'b0);
      txn("R4", 32'h2010_0000, 1'b0, 1'b0);
      txn("R4", 32'h1FFF_FFFF, 1'b1, 1'b0);
      txn("R6", 32'h2000_0000, 1'b1, 1'b1);

      // R3 byte strobes: disable via top lane only
      cfg_wr(8'h00, 4'b1000, 32'h0000_0000);
      chk_rd("R3", 8'h00);
      chk("R3", {32'h0, cfg_rdata}, 64'h0010_2000);
      txn("R3", 32'h2000_0000, 1'b0, 1'b0);
      cfg_wr(8'h00, 4'b1000, 32'h8000_0000);
      chk_rd("R3", 8'h00);
      chk("R3", {32'h0, cfg_rdata}, 64'h8010_2000);
      cfg_wr(8'h08, 4'b0010, 32'h0000_AB00);
      chk_rd("R3", 8'h08);

      // R4 size zero closes
      cfg_wr(8'h08, 4'hF, 32'h0);
      txn("R4", 32'h2000_0000, 1'b0, 1'b0);
      cfg_wr(8'h08, 4'hF, 32'h0000_000F);

      // R6 write-forbidden window
      cfg_wr(8'h10, 4'hF, 32'h8020_3000);
      cfg_wr(8'h18, 4'hF, 32'h0000_00FF);
      txn("R6", 32'h3000_1000, 1'b0, 1'b0);
      txn("R6", 32'h30FF_0000, 1'b1, 1'b0);

      // R7 cache-forbidden
      cfg_wr(8'h20, 4'hF, 32'h8040_4000);
      cfg_wr(8'h28, 4'hF, 32'h0000_003F);
      txn("R7", 32'h4012_3400, 1'b0, 1'b1);
      txn("R7", 32'h4012_3400, 1'b1, 1'b0);
      cfg_wr(8'h30, 4'hF, 32'h8050_5000);
      cfg_wr(8'h38, 4'hF, 32'h0000_000F);
      txn("R7", 32'h5000_0040, 1'b0, 1'b1);

      // R8 lowest index wins
      cfg_wr(8'h40, 4'hF, 32'h8000_6100);
      cfg_wr(8'h48, 4'hF, 32'h0000_000F);
      cfg_wr(8'h50, 4'hF, 32'h8010_6000);
      cfg_wr(8'h58, 4'hF, 32'h0000_0FFF);
      txn("R8", 32'h6100_0000, 1'b1, 1'b0);
      txn("R8", 32'h6200_0000, 1'b0, 1'b0);

      // R9 internal space exempt
      cfg_wr(8'h60, 4'hF, 32'h8050_1000);
      cfg_wr(8'h68, 4'hF, 32'h0000_0FFF);
      txn("R9", 32'h1400_1234, 1'b1, 1'b1);
      txn("R9", 32'h1401_0000, 1'b0, 1'b0);
      cfg_wr(8'h84, 4'hF, 32'hFFFF_1401);
      chk_rd("R9", 8'h84);
      chk("R9", {32'h0, cfg_rdata}, 64'h0000_1401);
      txn("R9", 32'h1401_0008, 1'b0, 1'b1);
      txn("R9", 32'h1400_1234, 1'b0, 1'b0);

      // R10 record, hold, clear
      cfg_wr(8'h80, 4'h1, 32'h1);
      chk("R10", {63'h0, viol_valid}, 64'h0);
      txn("R10", 32'h2000_0100, 1'b1, 1'b0);
      txn("R10", 32'h5000_0200, 1'b0, 1'b1);
      cfg_wr(8'h80, 4'h2, 32'h1);
      chk("R10", {63'h0, viol_valid}, 64'h1);
      cfg_wr(8'h80, 4'h1, 32'h0);
      chk("R10", {63'h0, viol_valid}, 64'h1);

      // R11 clear on the same edge as a new denial
      txn_cfg("R11", 32'h200A_0000, 1'b0, 1'b1, 1'b1, 8'h80, 4'h1, 32'h1);
      chk("R11", {32'h0, viol_addr}, 64'h200A_0000);
      // R11 reprogram on the same edge as a transaction: old contents judge it
      txn_cfg("R11", 32'h2000_0000, 1'b0, 1'b0, 1'b1, 8'h00, 4'b1000, 32'h0);
      txn("R11", 32'h2000_0000, 1'b0, 1'b0);

      // R5 single-cycle result
      txn("R5", 32'h3000_0000, 1'b1, 1'b0);
      @(negedge clk);
      chk("R5", {60'h0, res_valid, res_allow, res_deny, res_cache_block}, 64'h0);

      // random windows
      cfg_wr(8'h80, 4'h1, 32'h1);
      for (int i = 0; i < 8; i++) begin
         k  = $urandom_range(4, 9);
         m  = 16'((32'h1 << k) - 1);
         pg = 16'($urandom) & ~m;
         cfg_wr(8'(i * 16), 4'hF,
                {($urandom % 4) != 0, 8'h0, 3'($urandom), 4'h0, pg});
         cfg_wr(8'(i * 16 + 8), 4'hF, {16'($urandom), m});
         chk_rd("R2", 8'(i * 16));
      end
      for (int n = 0; n < 250; n++) begin
         j  = $urandom_range(0, 7);
         m  = ms[j][15:0];
         pg = (mb[j][15:0] & ~m) | (16'($urandom) & ((m << 1) | 16'h1));
         if (n % 23 == 0) pg = mint[15:0];
         if (n % 17 == 5) cfg_wr(8'h80, 4'h1, 32'h1);
         if (n % 11 == 3)
            txn_cfg("R11", {pg, 16'($urandom)}, 1'($urandom), 1'($urandom),
                    1'b1, 8'(j * 16), 4'b1000, {1'($urandom), 31'h0});
         else
            txn("R6", {pg, 16'($urandom)}, 1'($urandom), 1'($urandom));
      end
      for (int n = 0; n < 30; n++) begin
         j = $urandom_range(0, 15);
         cfg_wr(8'((j / 2) * 16 + (j % 2) * 8), 4'($urandom), $urandom);
         chk_rd("R3", 8'((j / 2) * 16 + (j % 2) * 8));
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule